// File: doc/BRIEF.md
# Planar Video Memory Write Path

This block is the processor-facing write path of a frame buffer split into four bit planes. A single byte address selects the same byte in all four planes. On each processor write the block builds one byte per plane and stores each into that plane's memory. How the byte is built depends on one of four write modes. The modes draw on the processor byte after a right rotate, on a per-plane fill colour with a per-plane override mask, on a per-bit mask, and on four read latches that hold the byte most recently read from every plane.

A processor read loads all four latches from the addressed location. It returns the latch of one plane, picked by a read-plane select setting. Write modes that merge latch bits therefore work as read-modify-write: software reads a location, then writes it, and the bits that are not selected keep their old value. The settings sit in a small register file behind a separate write port. A new setting applies to the next processor write. A plane write-enable mask stops chosen planes from being updated.

Top module: `vgaw_write_path`

## Requirements
- R1: After reset every read latch and `cpu_rdata` read 0. The write mode is 0, the rotate count 0, the fill colour and the override mask 0, the bit mask 0xFF, all four planes are write-enabled and the read-plane select is 0.
- R2: In write mode 0, a plane whose override bit is 0 stores the processor byte rotated right by the rotate count (0 to 7).
- R3: In write mode 0, a plane whose override bit is 1 stores its fill-colour bit copied into all eight positions.
- R4: In write mode 1, every plane stores the current contents of its own read latch.
- R5: In write mode 2, processor data bit p is the colour of plane p. Where a bit-mask bit is 1 the plane stores that colour bit. Where it is 0 the plane stores the latch bit.
- R6: In write mode 3, the effective mask is the processor byte ANDed with the bit mask. Where that mask is 1 a plane stores its fill-colour bit. Where it is 0 the plane stores the latch bit.
- R7: A plane whose write-enable bit is 0 keeps its contents on a processor write. The other planes are written as usual.
- R8: A read strobe loads all four latches from the addressed byte on the next clock edge. `cpu_rdata` always shows the latch of the plane named by the read-plane select, and the latches do not change without a read strobe.
- R9: A register write with `reg_sel` 0 to 6 sets, from `reg_wdata` low bits, one of the following: write mode [1:0], rotate count [2:0], fill colour [3:0] (bit p belongs to plane p), override mask [3:0], bit mask [7:0], plane write-enable [3:0], read-plane select [1:0]. The new value applies from the next clock edge. `reg_sel` 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | ADDR_W | Byte address shared by all planes |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_rdata | output | 8 | Latch of the selected plane |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write value |

## Verification
The bench targets rotate counts of 3 and 7. If the rotation ran the wrong way or wrapped wrongly, the plane bytes would come out shifted the other way or with bits dropped. It mixes overridden and plain planes in one write, so an override bit tied to the wrong plane shows up as a fill in the wrong plane. It sets bit masks of 0x00, 0xF0 and 0xFF in mode 2, and in mode 3 a processor byte that overlaps the mask only in part. A design that took unmasked bits from the processor instead of the latch, or that ignored the AND with the processor byte, would corrupt the untouched bits. It also writes with two planes disabled, which catches a plane that gets overwritten anyway. It changes the read-plane select without a new read, which catches a design that returns memory contents instead of the held latch.

// File: rtl/vgaw_pkg.sv
// Shared widths, register codes and types for the planar write path.
// Assumes four planes of byte-wide storage.
package vgaw_pkg;
    localparam int PLANES  = 4;
    localparam int BYTE_W  = 8;
    localparam int ROT_W   = $clog2(BYTE_W);
    localparam int PSEL_W  = $clog2(PLANES);
    localparam int RSEL_W  = 3;

    typedef enum logic [1:0] {
        WM_ROTATE  = 2'd0,
        WM_LATCH   = 2'd1,
        WM_COLOUR  = 2'd2,
        WM_SETMASK = 2'd3
    } wmode_e;

    localparam logic [RSEL_W-1:0] SEL_MODE  = 3'd0;
    localparam logic [RSEL_W-1:0] SEL_ROT   = 3'd1;
    localparam logic [RSEL_W-1:0] SEL_FILL  = 3'd2;
    localparam logic [RSEL_W-1:0] SEL_OVR   = 3'd3;
    localparam logic [RSEL_W-1:0] SEL_BMASK = 3'd4;
    localparam logic [RSEL_W-1:0] SEL_PWE   = 3'd5;
    localparam logic [RSEL_W-1:0] SEL_RDPL  = 3'd6;

    typedef struct packed {
        wmode_e              mode;
        logic [ROT_W-1:0]    rot;
        logic [PLANES-1:0]   fill;
        logic [PLANES-1:0]   ovr;
        logic [BYTE_W-1:0]   bmask;
        logic [PLANES-1:0]   pwe;
        logic [PSEL_W-1:0]   rdpl;
    } cfg_t;
endpackage

// File: rtl/vgaw_cfg_regs.sv
// Register file holding the write-path settings.
// Assumes one register write per cycle; unknown selects are ignored.
module vgaw_cfg_regs
    import vgaw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [RSEL_W-1:0]   reg_sel,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output cfg_t                cfg
);
    // Purpose: load the selected field, reset to documented defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.mode  <= WM_ROTATE;
            cfg.rot   <= '0;
            cfg.fill  <= '0;
            cfg.ovr   <= '0;
            cfg.bmask <= '1;
            cfg.pwe   <= '1;
            cfg.rdpl  <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_MODE:  cfg.mode  <= wmode_e'(reg_wdata[1:0]);
                SEL_ROT:   cfg.rot   <= reg_wdata[ROT_W-1:0];
                SEL_FILL:  cfg.fill  <= reg_wdata[PLANES-1:0];
                SEL_OVR:   cfg.ovr   <= reg_wdata[PLANES-1:0];
                SEL_BMASK: cfg.bmask <= reg_wdata;
                SEL_PWE:   cfg.pwe   <= reg_wdata[PLANES-1:0];
                SEL_RDPL:  cfg.rdpl  <= reg_wdata[PSEL_W-1:0];
                default:   ;
            endcase
        end
    end

    // R9: settings hold without a register write
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(cfg));
    // R9: select 7 touches nothing
    assert_sel7_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd7) |=> $stable(cfg));
endmodule

// File: rtl/vgaw_lane_former.sv
// Builds the byte one plane receives on a processor write.
// Purely combinational; PLANE picks which colour/data bit belongs here.
module vgaw_lane_former
    import vgaw_pkg::*;
#(
    parameter int PLANE = 0
) (
    input  wmode_e              mode,
    input  logic [ROT_W-1:0]    rot,
    input  logic                fill_bit,
    input  logic                ovr_bit,
    input  logic [BYTE_W-1:0]   bmask,
    input  logic [BYTE_W-1:0]   cpu_data,
    input  logic [BYTE_W-1:0]   latch,
    output logic [BYTE_W-1:0]   lane_byte
);
    logic [2*BYTE_W-1:0] dbl;
    logic [BYTE_W-1:0]   rotated;
    logic [BYTE_W-1:0]   fill_byte;
    logic [BYTE_W-1:0]   colour_byte;
    logic [BYTE_W-1:0]   eff_mask;

    // Purpose: right rotate and replicated constants.
    always_comb begin
        dbl         = {cpu_data, cpu_data} >> rot;
        rotated     = dbl[BYTE_W-1:0];
        fill_byte   = {BYTE_W{fill_bit}};
        colour_byte = {BYTE_W{cpu_data[PLANE]}};
        eff_mask    = cpu_data & bmask;
    end

    // Purpose: pick the plane byte by write mode.
    always_comb begin
        unique case (mode)
            WM_ROTATE:  lane_byte = ovr_bit ? fill_byte : rotated;
            WM_LATCH:   lane_byte = latch;
            WM_COLOUR:  lane_byte = (bmask & colour_byte) | (~bmask & latch);
            WM_SETMASK: lane_byte = (eff_mask & fill_byte) | (~eff_mask & latch);
            default:    lane_byte = latch;
        endcase
    end
endmodule

// File: rtl/vgaw_plane_mem.sv
// One plane of byte storage: synchronous write, combinational read.
// Contents are not reset; software writes before it reads.
module vgaw_plane_mem
    import vgaw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [BYTE_W-1:0] mem_q [DEPTH];

    // Purpose: store the plane byte on an enabled write.
    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];

    // R7: an enabled write lands at the addressed byte
    assert_plane_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (addr != $past(addr) || rdata == $past(wdata)));
endmodule

// File: rtl/vgaw_write_path.sv
// Top of the four-plane write path: registers, per-plane formers,
// plane memories and read latches. Read and write in one cycle see
// the memory contents from before that edge.
module vgaw_write_path
    import vgaw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                cpu_wr,
    input  logic                cpu_rd,
    output logic [7:0]          cpu_rdata,
    input  logic                reg_wr,
    input  logic [2:0]          reg_sel,
    input  logic [7:0]          reg_wdata
);
    cfg_t              cfg;
    logic [BYTE_W-1:0] latch_q  [PLANES];
    logic [BYTE_W-1:0] lane_b   [PLANES];
    logic [BYTE_W-1:0] plane_rd [PLANES];

    vgaw_cfg_regs i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .cfg       (cfg)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        vgaw_lane_former #(.PLANE(p)) i_former (
            .mode      (cfg.mode),
            .rot       (cfg.rot),
            .fill_bit  (cfg.fill[p]),
            .ovr_bit   (cfg.ovr[p]),
            .bmask     (cfg.bmask),
            .cpu_data  (cpu_wdata),
            .latch     (latch_q[p]),
            .lane_byte (lane_b[p])
        );

        vgaw_plane_mem #(.ADDR_W(ADDR_W)) i_mem (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (cpu_wr & cfg.pwe[p]),
            .addr  (cpu_addr),
            .wdata (lane_b[p]),
            .rdata (plane_rd[p])
        );

        // Purpose: capture this plane's addressed byte on a read strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)      latch_q[p] <= '0;
            else if (cpu_rd) latch_q[p] <= plane_rd[p];
        end

        // R2: rotation keeps the number of set bits
        assert_rotate_popcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.mode == WM_ROTATE && !cfg.ovr[p]) |->
                $countones(lane_b[p]) == $countones(cpu_wdata));
        // R3: an overridden plane gets a solid byte
        assert_override_solid_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.mode == WM_ROTATE && cfg.ovr[p]) |->
                ($countones(lane_b[p]) == 0 || $countones(lane_b[p]) == BYTE_W));
        // R4: latch copy mode
        assert_latch_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.mode == WM_LATCH) |-> lane_b[p] == latch_q[p]);
        // R5: unmasked bits come from the latch
        assert_colour_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.mode == WM_COLOUR) |-> ((lane_b[p] ^ latch_q[p]) & ~cfg.bmask) == '0);
        // R6: bits outside data AND mask come from the latch
        assert_setmask_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.mode == WM_SETMASK) |->
                ((lane_b[p] ^ latch_q[p]) & ~(cpu_wdata & cfg.bmask)) == '0);
        // R7: disabled plane keeps its byte
        assert_plane_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr && !cfg.pwe[p]) |=>
                (cpu_addr != $past(cpu_addr) || plane_rd[p] == $past(plane_rd[p])));
        // R8: latch loads the addressed byte after a read
        assert_latch_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_rd |=> latch_q[p] == $past(plane_rd[p]));
        // R8: latch holds without a read
        assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_rd |=> $stable(latch_q[p]));
    end

    assign cpu_rdata = latch_q[cfg.rdpl];
endmodule

// File: tb/test_vgaw_write_path.sv
// Scoreboard bench: driver tasks keep a plane model and queue expected
// read bytes; a monitor compares them one cycle after each read strobe.
module test_vgaw_write_path;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic          cpu_wr = 1'b0;
    logic          cpu_rd = 1'b0;
    logic [7:0]    cpu_rdata;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [7:0]    reg_wdata = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // model state
    logic [7:0] m_mem [4][1<<AW];
    logic [7:0] m_latch [4];
    logic [1:0] m_mode = 0;
    logic [2:0] m_rot = 0;
    logic [3:0] m_fill = 0, m_ovr = 0, m_pwe = 4'hF;
    logic [7:0] m_bm = 8'hFF;
    logic [1:0] m_rdpl = 0;

    always #10 clk = ~clk;   // 50 MHz

    vgaw_write_path #(.ADDR_W(AW)) i_vgaw_write_path (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ror(logic [7:0] d, int k);
        logic [7:0] r = d;
        for (int i = 0; i < k; i++) r = {r[0], r[7:1]};
        return r;
    endfunction

    function automatic logic [7:0] mdl_form(int p, logic [7:0] d);
        logic [7:0] mk;
        case (m_mode)
            2'd0: return m_ovr[p] ? {8{m_fill[p]}} : ror(d, int'(m_rot));
            2'd1: return m_latch[p];
            2'd2: return (m_bm & {8{d[p]}}) | (~m_bm & m_latch[p]);
            default: begin
                mk = d & m_bm;
                return (mk & {8{m_fill[p]}}) | (~mk & m_latch[p]);
            end
        endcase
    endfunction

    task automatic reg_write(logic [2:0] s, logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        case (s)
            3'd0: m_mode = v[1:0];
            3'd1: m_rot  = v[2:0];
            3'd2: m_fill = v[3:0];
            3'd3: m_ovr  = v[3:0];
            3'd4: m_bm   = v;
            3'd5: m_pwe  = v[3:0];
            3'd6: m_rdpl = v[1:0];
            default: ;
        endcase
    endtask

    task automatic cpu_write(logic [AW-1:0] a, logic [7:0] d);
        for (int p = 0; p < 4; p++)
            if (m_pwe[p]) m_mem[p][a] = mdl_form(p, d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(logic [AW-1:0] a, logic [1:0] p, string tag);
        reg_write(3'd6, {6'd0, p});
        exp_q.push_back(m_mem[p][a]);
        tag_q.push_back(tag);
        for (int q = 0; q < 4; q++) m_latch[q] = m_mem[q][a];
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic read_all(logic [AW-1:0] a, string tag);
        for (int p = 0; p < 4; p++) cpu_read(a, p[1:0], tag);
    endtask

    // monitor: pop one expectation per read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (cpu_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R8 unexpected read actual=%02h expected=none", cpu_rdata);
                end else begin
                    check(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++; checks++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 4; p++) m_latch[p] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", cpu_rdata, 8'h00);

        // R1: defaults give a plain mode 0 write to every plane
        cpu_write(6'd1, 8'hA5);
        read_all(6'd1, "R1 default write");

        // R2: rotate counts
        reg_write(3'd1, 8'd3);
        cpu_write(6'd2, 8'h81);
        read_all(6'd2, "R2 rotate 3");
        reg_write(3'd1, 8'd7);
        cpu_write(6'd5, 8'h96);
        read_all(6'd5, "R2 rotate 7");
        reg_write(3'd1, 8'd0);

        // R3: overrides on planes 0 and 2, fill only plane 0
        reg_write(3'd2, 8'h01);
        reg_write(3'd3, 8'h05);
        cpu_write(6'd3, 8'h3C);
        read_all(6'd3, "R3 override");
        reg_write(3'd3, 8'h00);

        // R4: latch copy
        read_all(6'd3, "R4 source");
        reg_write(3'd0, 8'd1);
        cpu_write(6'd9, 8'hFF);
        read_all(6'd9, "R4 latch copy");

        // R5: colour mode with three masks
        reg_write(3'd0, 8'd2);
        reg_write(3'd4, 8'hF0);
        cpu_write(6'd11, 8'h06);
        read_all(6'd11, "R5 mask F0");
        reg_write(3'd4, 8'h00);
        cpu_write(6'd13, 8'h0F);
        read_all(6'd13, "R5 mask 00");
        reg_write(3'd4, 8'hFF);
        cpu_write(6'd14, 8'h09);
        read_all(6'd14, "R5 mask FF");

        // R6: data AND mask selects fill bits
        read_all(6'd3, "R6 source");
        reg_write(3'd0, 8'd3);
        reg_write(3'd2, 8'h0A);
        reg_write(3'd4, 8'h3C);
        cpu_write(6'd15, 8'hF0);
        read_all(6'd15, "R6 set mask");

        // R7: planes 0 and 3 disabled
        reg_write(3'd0, 8'd0);
        reg_write(3'd4, 8'hFF);
        reg_write(3'd5, 8'h06);
        cpu_write(6'd1, 8'h3C);
        reg_write(3'd5, 8'h0F);
        read_all(6'd1, "R7 plane enable");

        // R9: select 7 ignored, following write unchanged
        reg_write(3'd7, 8'hFF);
        cpu_write(6'd12, 8'h5A);
        read_all(6'd12, "R9 select 7");

        // R8: select change shows held latches without a new read
        cpu_read(6'd3, 2'd0, "R8 read plane0");
        for (int p = 1; p < 4; p++) begin
            reg_write(3'd6, p[7:0]);
            check("R8 latch select", cpu_rdata, m_latch[p]);
        end

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule